// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog

This block is a watchdog timer with a single 32-bit control word. It sits on a simple write port. Software arms the watchdog with a command bit and a reload count. Once armed, software has to keep feeding it. Every feed must carry a 7-bit key equal to the one's complement of the key stored by the previous accepted write. A stray write that repeats an old key, or that lands at any other address, cannot keep a runaway program alive.

The counter advances only on cycles where a slow tick-enable input is high. When it runs out the first time, the block raises a non-maskable interrupt. It then gives software a short grace countdown in which to respond. If that grace countdown also runs out with no accepted write, the block emits a one-cycle system reset request.

Top module: `wdog_keyed`

## Requirements
- R1: A write is decoded only when `addr` equals `CTRL_ADDR` (default 0x40). While the stored command bit (bit 8) is 0, the watchdog is unlocked and a write at that address is accepted whatever key it carries. A write to any other address has no effect.
- R2: While the stored bit 8 is 1, a write is accepted only if its key field `wr_data[15:9]` equals the 7-bit bitwise inverse of the stored key. Any other write has no effect on the counter, the stored word or the outputs.
- R3: An accepted write with bit 8 set reloads the counter from `wr_data[8:0]` (a value of 0 is taken as 256) and starts it. The first expiry comes on the tick that takes the count from 1 to 0, that is, on the N-th counting tick after the write.
- R4: The counter changes only on cycles where `tick` is high. Cycles with `tick` low delay expiry by exactly their number.
- R5: On the first expiry `nmi` goes high in the cycle after the expiring tick. It stays high until an accepted write or a reset.
- R6: After the first expiry the counter reloads with 10 ticks. If that grace countdown expires, `reset_req` is high for exactly one cycle and counting stops.
- R7: An accepted write lowers `nmi` in the next cycle and clears the expiry history. A later expiry then starts again with the interrupt stage.
- R8: An accepted write with bit 8 clear stops the counter, so no interrupt and no reset request follow.
- R9: Reset clears the stored word, which leaves the watchdog stopped and unlocked, and drives `nmi` and `reset_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data: key [15:9], command [8], count [8:0] |
| tick | input | 1 | Count enable, high one cycle per watchdog tick |
| nmi | output | 1 | Non-maskable interrupt level after first expiry |
| reset_req | output | 1 | One-cycle system reset request after grace expiry |

## Verification
The hardest state to reach from the ports is a rejected feed while the watchdog is locked. The write has no output of its own, so the only evidence is that expiry arrives at the cycle the earlier accepted write set. The stimulus therefore arms the counter and sends a repeated-key write and a wrong-address write partway through the countdown. It then predicts the expiry cycle from the first write alone. An accepted feed is checked the opposite way, by predicting a quiet cycle where the unfed expiry would have been. A stretch with `tick` low checks that expiry is delayed by exactly the length of the stretch.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40,
  parameter int KEY_W  = 7,
  parameter int CNT_W  = 9,
  parameter int GRACE  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  input  logic              tick,
  output logic              nmi,
  output logic              reset_req
);
  localparam int CMD_BIT = CNT_W - 1;
  localparam int KEY_LSB = CNT_W;
  localparam logic [CNT_W-1:0] ZERO_CNT = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] GRACE_CNT = CNT_W'(GRACE);

  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             hit;
  logic             nmi_q;
  logic             rreq_q;

  wire [KEY_W-1:0] key_old = ctrl_q[KEY_LSB +: KEY_W];
  wire [KEY_W-1:0] key_new = wr_data[KEY_LSB +: KEY_W];
  wire             locked  = ctrl_q[CMD_BIT];
  wire             sel     = wr_en && (addr == CTRL_ADDR);
  wire             accept  = sel && (!locked || key_new == ~key_old);
  wire [CNT_W-1:0] load    = (wr_data[CNT_W-1:0] == '0) ? ZERO_CNT : wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt     <= '0;
      running <= 1'b0;
      hit     <= 1'b0;
      nmi_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      rreq_q <= 1'b0;
      if (accept) begin
        ctrl_q  <= wr_data;
        cnt     <= load;
        running <= wr_data[CMD_BIT];
        hit     <= 1'b0;
        nmi_q   <= 1'b0;
      end else if (running && tick) begin
        if (cnt == CNT_W'(1)) begin
          if (!hit) begin
            hit   <= 1'b1;
            nmi_q <= 1'b1;
            cnt   <= GRACE_CNT;
          end else begin
            rreq_q  <= 1'b1;
            running <= 1'b0;
            cnt     <= '0;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  assign nmi       = nmi_q;
  assign reset_req = rreq_q;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40,
  parameter int KEY_W  = 7,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic              tick,
  input logic              nmi,
  input logic              reset_req,
  input logic [31:0]       ctrl_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              running
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r6_after_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> nmi);

  a_r5_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !wr_en) |=> nmi);

  a_r2_same_key_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CNT_W-1] && wr_en && addr == CTRL_ADDR &&
     wr_data[CNT_W +: KEY_W] == ctrl_q[CNT_W +: KEY_W]) |=> $stable(ctrl_q));

  a_r1_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == CTRL_ADDR)) |=> $stable(ctrl_q));

  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt));

  a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> (!reset_req && $stable(nmi)));
endmodule

bind wdog_keyed wdog_keyed_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .KEY_W(KEY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .tick(tick), .nmi(nmi), .reset_req(reset_req), .ctrl_q(ctrl_q),
  .cnt(cnt), .running(running)
);

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 100000;

  typedef struct {
    int    cyc;
    bit    nmi;
    bit    rst;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h40;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b1;
  logic        nmi;
  logic        reset_req;

  int   cyc = 0;
  int   vectors = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  wdog_keyed u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .tick(tick), .nmi(nmi), .reset_req(reset_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (e.cyc != cyc || nmi !== e.nmi || reset_req !== e.rst) begin
        errors++;
        $display("FAIL %s cyc %0d: nmi=%b reset_req=%b expected nmi=%b reset_req=%b at cyc %0d",
                 e.req, cyc, nmi, reset_req, e.nmi, e.rst, e.cyc);
      end
    end
  end

  task automatic push(input int c, input bit n, input bit r, input string req);
    exp_t e;
    e.cyc = c; e.nmi = n; e.rst = r; e.req = req;
    q.push_back(e);
  endtask

  task automatic chk(input bit n, input bit r, input string req);
    vectors++;
    if (nmi !== n || reset_req !== r) begin
      errors++;
      $display("FAIL %s: nmi=%b reset_req=%b expected nmi=%b reset_req=%b",
               req, nmi, reset_req, n, r);
    end
  endtask

  task automatic wr(input logic [6:0] key, input bit cmd, input logic [7:0] low,
                    input logic [7:0] a, output int w);
    wr_en = 1'b1;
    addr = a;
    wr_data = {16'h0, key, cmd, low};
    @(posedge clk);
    #1 wr_en = 1'b0;
    addr = 8'h40;
    @(negedge clk);
    w = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic escalate(input int w, input int n, input int gap, input string req);
    push(w + n + gap - 1, 1'b0, 1'b0, req);
    push(w + n + gap,     1'b1, 1'b0, req);
    push(w + n + gap + 9, 1'b1, 1'b0, req);
    push(w + n + gap + 10, 1'b1, 1'b1, req);
    push(w + n + gap + 11, 1'b1, 1'b0, req);
  endtask

  initial begin
    int w0, w1, wx;
    idle(3);
    chk(1'b0, 1'b0, "R9 reset state");
    rst_n = 1'b1;
    idle(2);

    // R1 unlocked any key, R3 count 256+4, R5 nmi, R6 grace then pulse
    wr(7'h2A, 1'b1, 8'd4, 8'h40, w0);
    escalate(w0, 260, 0, "R3_R5_R6 first escalation");
    drain();
    idle(5);
    chk(1'b1, 1'b0, "R5 nmi held after reset pulse");

    // R7 accepted complement clears nmi and history
    wr(7'h55, 1'b1, 8'd20, 8'h40, w0);
    chk(1'b0, 1'b0, "R7 nmi cleared by accepted write");
    escalate(w0, 276, 0, "R7 history cleared, interrupt stage first");
    drain();

    // R2 repeated key rejected; R1 wrong address ignored
    wr(7'h2A, 1'b1, 8'd0, 8'h40, w0);
    idle(50);
    wr(7'h2A, 1'b1, 8'd100, 8'h40, wx);
    idle(10);
    wr(7'h55, 1'b1, 8'd100, 8'h44, wx);
    escalate(w0, 256, 0, "R2_R1 rejected writes leave countdown");
    drain();

    // R3 accepted feed reloads
    wr(7'h55, 1'b1, 8'd0, 8'h40, w0);
    idle(100);
    wr(7'h2A, 1'b1, 8'd10, 8'h40, w1);
    push(w0 + 256, 1'b0, 1'b0, "R3 feed prevents old expiry");
    escalate(w1, 266, 0, "R3 expiry counted from feed");
    drain();

    // R4 tick gating
    wr(7'h55, 1'b1, 8'd0, 8'h40, w0);
    escalate(w0, 256, 40, "R4 tick low stretch delays expiry");
    idle(10);
    tick = 1'b0;
    idle(40);
    tick = 1'b1;
    drain();

    // R8 stop command
    wr(7'h2A, 1'b0, 8'd0, 8'h40, w0);
    chk(1'b0, 1'b0, "R8 stop write clears nmi");
    push(w0 + 300, 1'b0, 1'b0, "R8 stopped, no interrupt");
    push(w0 + 400, 1'b0, 1'b0, "R8 stopped, no reset request");
    drain();
    wr(7'h11, 1'b1, 8'd0, 8'h40, w0);
    escalate(w0, 256, 0, "R1 unlocked after stop accepts any key");
    drain();

    // R9 reset mid-run unlocks
    wr(7'h6E, 1'b1, 8'd0, 8'h40, w0);
    idle(20);
    rst_n = 1'b0;
    idle(2);
    chk(1'b0, 1'b0, "R9 reset clears outputs");
    rst_n = 1'b1;
    idle(300);
    chk(1'b0, 1'b0, "R9 reset stops counter");
    wr(7'h33, 1'b1, 8'd0, 8'h40, w0);
    escalate(w0, 256, 0, "R9 unlocked after reset");
    drain();
    idle(5);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < LIMIT) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", n, LIMIT);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule